// File: doc/BRIEF.md
# Sixty-Four-Way Data Cache Controller

This block is a 16KB data cache that sits between a processor's load/store port and a word-wide memory port. It has 8 sets of 64 ways. Each line holds eight 32-bit words and carries one valid bit and two dirty bits, one for each half of the line. The processor issues one request at a time: it raises `cpu_req` with a word address, a write flag and store data. It holds them until `cpu_ready` pulses for one cycle. For a load, `cpu_rdata` is valid during that pulse.

Two live inputs set the policies. `wb_mode` picks write-back (1) or write-through (0). `rand_repl` picks the victim either from a free-running pseudo-random sequence (1) or from a per-set round-robin counter (0). All memory writes go through a small posted write buffer. Evicted dirty halves enter it as 4-word bursts, and write-through stores enter it as single words. Line fills read memory directly, and only once the buffer is empty.

The controller is one state machine with five states. S_IDLE latches a request and moves to S_LOOK. S_LOOK compares all 64 tags of the set. On a hit, or on a write-through store miss, it answers and returns to S_IDLE; a full buffer holds it in S_LOOK. On any other miss it picks a victim and moves to S_EVICT. S_EVICT queues the victim's dirty halves (half 0, then half 1) and moves to S_DRAIN. S_DRAIN waits for an empty buffer, installs the new tag, and moves to S_FILL. S_FILL reads eight words and returns to S_LOOK, which now hits and completes the access.

Top module: `dcache_core`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low and every line is invalid, so the first access to any line misses.
- R2: A load hit answers with no memory traffic. A load miss reads the 8 words of the line from memory, then answers with the requested word.
- R3: Word address bits [5:3] select the set, bits [2:0] select the word, and bits [29:6] form the tag. 64 lines with different tags in one set are all resident at once.
- R4: In write-back mode a store hit updates the cache and marks the half containing the word dirty (words 0-3 are half 0, words 4-7 are half 1). It produces no memory write, and a later load returns the stored value.
- R5: When a valid victim is replaced, each dirty half is written to memory as 4 words at ascending addresses. A clean half produces no write.
- R6: In write-through mode a store hit updates the cache and posts the word to memory. A store miss posts the word without allocating, so a later load of it misses.
- R7: In write-back mode a store miss allocates a line, fills it from memory, then merges the store. A later load hits.
- R8: With `rand_repl`=0 the victim is the set's 6-bit counter, which starts at 0 and increments on every allocation in that set. With `rand_repl`=1 the victim is a 6-bit LFSR that advances every clock.
- R9: The write buffer holds at most 4 entries (16 words) and drains them in arrival order. A store that needs an entry while all 4 are taken does not complete until one frees.
- R10: A line fill starts only when the write buffer is empty, so a load of an address still waiting in the buffer returns the buffered value.
- R11: While `mem_req` is high without `mem_ack`, the request and its address stay unchanged on the next cycle.
- R12: `cpu_ready` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 selects write-back, 0 selects write-through |
| rand_repl | input | 1 | 1 selects pseudo-random victim, 0 selects round-robin |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 30 | Word address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory word request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Most wrong internal state reaches the ports within a single access. A wrong tag match or wrong word select shows up as wrong `cpu_rdata` on the next load, or as an unexpected count of 8-word reads. A wrong dirty bit or a wrong victim choice stays hidden until that line is replaced. It then shows as missing, extra or misplaced 4-word write bursts, or as a miss where a hit was expected, up to 64 allocations later in the same set. A wrong buffer count or ordering shows up as a store that completes despite a full buffer, as writes leaving in the wrong order, or as a load that returns stale data.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int WA_W        = 30;
    localparam int DATA_W      = 32;
    localparam int WAYS        = 64;
    localparam int SETS        = 8;
    localparam int LINE_WORDS  = 8;
    localparam int WB_ENTRIES  = 4;
    localparam int WAY_W       = $clog2(WAYS);
    localparam int SET_W       = $clog2(SETS);
    localparam int WORD_W      = $clog2(LINE_WORDS);
    localparam int TAG_W       = WA_W - SET_W - WORD_W;
    localparam int HALF_WORDS  = LINE_WORDS / 2;
    localparam int ROW_W       = SET_W + WAY_W;
    localparam int LVL_W       = $clog2(WB_ENTRIES + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_EVICT, S_DRAIN, S_FILL
    } dc_state_t;
endpackage

// File: rtl/dc_store.sv
module dc_store
    import dc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [SET_W-1:0]                   set_i,
    input  logic [TAG_W-1:0]                   tag_i,
    input  logic [WAY_W-1:0]                   way_i,
    output logic                               hit_o,
    output logic [WAY_W-1:0]                   hit_way_o,
    output logic [LINE_WORDS-1:0][DATA_W-1:0]  line_o,
    output logic                               row_valid_o,
    output logic [1:0]                         row_dirty_o,
    output logic [TAG_W-1:0]                   row_tag_o,
    input  logic                               data_we_i,
    input  logic [WORD_W-1:0]                  word_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    input  logic                               tag_we_i,
    input  logic                               dirty_we_i,
    input  logic                               half_i
);
    logic [DATA_W-1:0]           data_q [SETS*WAYS*LINE_WORDS];
    logic [TAG_W-1:0]            tag_q  [SETS*WAYS];
    logic [SETS*WAYS-1:0]        valid_q;
    logic [SETS*WAYS-1:0][1:0]   dirty_q;
    logic [ROW_W-1:0]            row;

    assign row = {set_i, way_i};

    // Parallel compare across every way of the set
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[{set_i, WAY_W'(w)}] && tag_q[{set_i, WAY_W'(w)}] == tag_i) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
        end
    end

    always_comb begin
        for (int j = 0; j < LINE_WORDS; j++)
            line_o[j] = data_q[{row, WORD_W'(j)}];
    end

    assign row_valid_o = valid_q[row];
    assign row_dirty_o = dirty_q[row];
    assign row_tag_o   = tag_q[row];

    always_ff @(posedge clk) begin
        if (data_we_i) data_q[{row, word_i}] <= wdata_i;
        if (tag_we_i)  tag_q[row] <= tag_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (tag_we_i) begin
            valid_q[row] <= 1'b1;
            dirty_q[row] <= 2'b00;
        end else if (dirty_we_i) begin
            dirty_q[row][half_i] <= 1'b1;
        end
    end
endmodule

// File: rtl/dc_victim.sv
module dc_victim
    import dc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rand_i,
    input  logic [SET_W-1:0]   set_i,
    input  logic               alloc_i,
    output logic [WAY_W-1:0]   way_o
);
    logic [WAY_W-1:0]             lfsr_q;
    logic [SETS-1:0][WAY_W-1:0]   rr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= WAY_W'(1);
            rr_q   <= '0;
        end else begin
            lfsr_q <= {lfsr_q[WAY_W-2:0], lfsr_q[WAY_W-1] ^ lfsr_q[WAY_W-2]};
            if (alloc_i) rr_q[set_i] <= rr_q[set_i] + 1'b1;
        end
    end

    assign way_o = rand_i ? lfsr_q : rr_q[set_i];
endmodule

// File: rtl/dc_wbuf.sv
module dc_wbuf
    import dc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push_i,
    input  logic                               push_burst_i,
    input  logic [WA_W-1:0]                    push_addr_i,
    input  logic [HALF_WORDS-1:0][DATA_W-1:0]  push_data_i,
    input  logic                               ack_i,
    output logic                               full_o,
    output logic                               empty_o,
    output logic [LVL_W-1:0]                   level_o,
    output logic                               req_o,
    output logic [WA_W-1:0]                    addr_o,
    output logic [DATA_W-1:0]                  wdata_o
);
    localparam int PTR_W  = $clog2(WB_ENTRIES);
    localparam int BEAT_W = $clog2(HALF_WORDS);

    logic [WA_W-1:0]                    addr_q  [WB_ENTRIES];
    logic [HALF_WORDS-1:0][DATA_W-1:0]  data_q  [WB_ENTRIES];
    logic [WB_ENTRIES-1:0]              burst_q;
    logic [PTR_W-1:0]                   head_q, tail_q;
    logic [BEAT_W-1:0]                  beat_q;
    logic [LVL_W-1:0]                   count_q;
    logic                               pop;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == LVL_W'(WB_ENTRIES));
    assign level_o = count_q;
    assign req_o   = !empty_o;
    assign addr_o  = addr_q[head_q] + WA_W'(beat_q);
    assign wdata_o = data_q[head_q][beat_q];
    assign pop     = ack_i && (!burst_q[head_q] || beat_q == BEAT_W'(HALF_WORDS-1));

    always_ff @(posedge clk) begin
        if (push_i) begin
            addr_q[tail_q]  <= push_addr_i;
            data_q[tail_q]  <= push_data_i;
            burst_q[tail_q] <= push_burst_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            beat_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_i) tail_q <= tail_q + 1'b1;
            if (pop)    head_q <= head_q + 1'b1;
            if (ack_i)  beat_q <= pop ? '0 : beat_q + 1'b1;
            count_q <= count_q + LVL_W'(push_i) - LVL_W'(pop);
        end
    end
endmodule

// File: rtl/dcache_core.sv
module dcache_core
    import dc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wb_mode,
    input  logic               rand_repl,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [WA_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata
);
    dc_state_t                        state_q, state_d;
    logic [WA_W-1:0]                  req_addr_q;
    logic                             req_we_q;
    logic [DATA_W-1:0]                req_wdata_q;
    logic [WAY_W-1:0]                 vic_way_q, vic_way;
    logic                             half_q;
    logic [WORD_W-1:0]                fill_cnt_q;

    logic [TAG_W-1:0]                 req_tag;
    logic [SET_W-1:0]                 req_set;
    logic [WORD_W-1:0]                req_word;
    logic                             hit, row_valid, in_fill;
    logic [WAY_W-1:0]                 hit_way, way_sel;
    logic [LINE_WORDS-1:0][DATA_W-1:0] line_rd;
    logic [1:0]                       row_dirty;
    logic [TAG_W-1:0]                 row_tag;
    logic                             data_we, tag_we, dirty_we, alloc;
    logic [WORD_W-1:0]                st_word;
    logic [DATA_W-1:0]                st_data;
    logic                             push, push_burst, evict_step;
    logic [WA_W-1:0]                  push_addr;
    logic [HALF_WORDS-1:0][DATA_W-1:0] push_data;
    logic                             wb_full, wb_empty, wb_req;
    logic [LVL_W-1:0]                 wb_level;
    logic [WA_W-1:0]                  wb_addr;
    logic [DATA_W-1:0]                wb_wdata;

    assign req_tag  = req_addr_q[WA_W-1 -: TAG_W];
    assign req_set  = req_addr_q[WORD_W +: SET_W];
    assign req_word = req_addr_q[WORD_W-1:0];
    assign in_fill  = (state_q == S_FILL);

    dc_store u_store (
        .clk(clk), .rst_n(rst_n), .set_i(req_set), .tag_i(req_tag), .way_i(way_sel),
        .hit_o(hit), .hit_way_o(hit_way), .line_o(line_rd),
        .row_valid_o(row_valid), .row_dirty_o(row_dirty), .row_tag_o(row_tag),
        .data_we_i(data_we), .word_i(st_word), .wdata_i(st_data),
        .tag_we_i(tag_we), .dirty_we_i(dirty_we), .half_i(req_word[WORD_W-1])
    );

    dc_victim u_victim (
        .clk(clk), .rst_n(rst_n), .rand_i(rand_repl), .set_i(req_set),
        .alloc_i(alloc), .way_o(vic_way)
    );

    dc_wbuf u_wbuf (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_burst_i(push_burst),
        .push_addr_i(push_addr), .push_data_i(push_data), .ack_i(mem_ack && !in_fill),
        .full_o(wb_full), .empty_o(wb_empty), .level_o(wb_level),
        .req_o(wb_req), .addr_o(wb_addr), .wdata_o(wb_wdata)
    );

    // Memory port: the fill owns it in S_FILL, the write buffer otherwise
    assign mem_req   = in_fill | wb_req;
    assign mem_we    = !in_fill & wb_req;
    assign mem_addr  = in_fill ? {req_tag, req_set, fill_cnt_q} : wb_addr;
    assign mem_wdata = wb_wdata;
    assign cpu_rdata = line_rd[req_word];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request, victim and fill registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            vic_way_q   <= '0;
            half_q      <= 1'b0;
            fill_cnt_q  <= '0;
        end else begin
            if (state_q == S_IDLE && cpu_req) begin
                req_addr_q  <= cpu_addr;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
            end
            if (alloc) begin
                vic_way_q <= vic_way;
                half_q    <= 1'b0;
            end
            if (state_q == S_EVICT && evict_step) half_q <= 1'b1;
            if (tag_we) fill_cnt_q <= '0;
            else if (in_fill && mem_ack) fill_cnt_q <= fill_cnt_q + 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        data_we    = 1'b0;
        tag_we     = 1'b0;
        dirty_we   = 1'b0;
        alloc      = 1'b0;
        push       = 1'b0;
        push_burst = 1'b0;
        push_addr  = req_addr_q;
        for (int j = 0; j < HALF_WORDS; j++) push_data[j] = req_wdata_q;
        way_sel    = vic_way_q;
        st_word    = req_word;
        st_data    = req_wdata_q;
        evict_step = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req) state_d = S_LOOK;
            end
            S_LOOK: begin
                way_sel = hit_way;
                if (hit && !req_we_q) begin
                    cpu_ready = 1'b1;
                    state_d   = S_IDLE;
                end else if (hit && wb_mode) begin
                    data_we   = 1'b1;
                    dirty_we  = 1'b1;
                    cpu_ready = 1'b1;
                    state_d   = S_IDLE;
                end else if (req_we_q && !wb_mode) begin
                    if (!wb_full) begin
                        data_we   = hit;
                        push      = 1'b1;
                        cpu_ready = 1'b1;
                        state_d   = S_IDLE;
                    end
                end else if (!hit) begin
                    alloc   = 1'b1;
                    state_d = S_EVICT;
                end
            end
            S_EVICT: begin
                for (int j = 0; j < HALF_WORDS; j++)
                    push_data[j] = line_rd[int'(half_q) * HALF_WORDS + j];
                push_addr  = {row_tag, req_set, half_q, {(WORD_W-1){1'b0}}};
                push_burst = 1'b1;
                if (row_valid && row_dirty[half_q]) begin
                    push       = !wb_full;
                    evict_step = !wb_full;
                end else begin
                    evict_step = 1'b1;
                end
                if (evict_step && half_q) state_d = S_DRAIN;
            end
            S_DRAIN: begin
                if (wb_empty) begin
                    tag_we  = 1'b1;
                    state_d = S_FILL;
                end
            end
            S_FILL: begin
                st_word = fill_cnt_q;
                st_data = mem_rdata;
                data_we = mem_ack;
                if (mem_ack && fill_cnt_q == WORD_W'(LINE_WORDS-1)) state_d = S_LOOK;
            end
        endcase
    end
endmodule

// File: rtl/dcache_core_checker.sv
module dcache_core_checker
    import dc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [WA_W-1:0]  mem_addr,
    input logic [LVL_W-1:0] wb_level,
    input logic             in_fill
);
    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_wbuf_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_level <= LVL_W'(WB_ENTRIES));

    assert_fill_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_fill) |-> (wb_level == '0));
endmodule

bind dcache_core dcache_core_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .wb_level(wb_level), .in_fill(in_fill)
);

// File: tb/test_dcache_core.sv
`timescale 1ns/1ps
module test_dcache_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b1, rand_repl = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [29:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_hold = 1'b0;

    int tests = 0, fails = 0, ops_done = 0, rd_count = 0;
    logic [31:0] mem   [logic [29:0]];
    logic [31:0] shadow[logic [29:0]];
    logic [29:0] wr_a[$];
    logic [31:0] wr_d[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    dcache_core i_dcache_core (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .rand_repl(rand_repl),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(input logic [29:0] a);
        return {2'b00, a} ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [31:0] mem_val(input logic [29:0] a);
        return mem.exists(a) ? mem[a] : init_val(a);
    endfunction

    function automatic logic [31:0] model(input logic [29:0] a);
        return shadow.exists(a) ? shadow[a] : init_val(a);
    endfunction

    function automatic logic [29:0] wa(input int tg, input int st, input int wd);
        return 30'((tg << 6) | (st << 3) | wd);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle acknowledge, logs every write
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_hold) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_a.push_back(mem_addr);
                wr_d.push_back(mem_wdata);
            end else begin
                mem_rdata <= mem_val(mem_addr);
                rd_count++;
            end
        end
    end

    // Driver: pushes the expected load result into the scoreboard
    task automatic cpu_op(input bit we, input logic [29:0] a, input logic [31:0] d, input string req);
        if (!we) begin
            exp_q.push_back(model(a));
            tag_q.push_back(req);
        end else begin
            shadow[a] = d;
        end
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b0;
        ops_done++;
        @(negedge clk);
        check(cpu_ready == 1'b0, "R12", 32'(cpu_ready), 32'd0);
    endtask

    // Monitor: pops expected load data on each completion
    always @(negedge clk) begin
        if (rst_n && cpu_ready && !cpu_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected load completion", cpu_rdata, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cpu_rdata == e, t, cpu_rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 reset outputs", {cpu_ready, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: first load misses and fills 8 words
        r0 = rd_count;
        cpu_op(1'b0, wa(1, 0, 1), 0, "R2 load miss data");
        check(rd_count - r0 == 8, "R1 R2 miss fill length", rd_count - r0, 8);
        r0 = rd_count;
        cpu_op(1'b0, wa(1, 0, 2), 0, "R2 load hit data");
        check(rd_count - r0 == 0, "R2 hit no read", rd_count - r0, 0);

        // R4: write-back store hit
        wr_a.delete(); wr_d.delete();
        cpu_op(1'b1, wa(1, 0, 3), 32'hDEAD_0003, "R4");
        repeat (6) @(negedge clk);
        check(wr_a.size() == 0, "R4 no memory write", wr_a.size(), 0);
        cpu_op(1'b0, wa(1, 0, 3), 0, "R4 load after store");

        // R6: write-through store hit posts one word
        wb_mode = 1'b0;
        cpu_op(1'b1, wa(1, 0, 4), 32'hBEEF_0004, "R6");
        repeat (6) @(negedge clk);
        check(wr_a.size() == 1, "R6 one posted write", wr_a.size(), 1);
        if (wr_a.size() == 1) begin
            check(wr_a[0] == wa(1, 0, 4), "R6 write address", 32'(wr_a[0]), 32'(wa(1, 0, 4)));
            check(wr_d[0] == 32'hBEEF_0004, "R6 write data", wr_d[0], 32'hBEEF_0004);
        end
        r0 = rd_count;
        cpu_op(1'b0, wa(1, 0, 4), 0, "R6 load after hit store");
        check(rd_count - r0 == 0, "R6 hit store kept line", rd_count - r0, 0);

        // R6/R10: write-through store miss does not allocate
        cpu_op(1'b1, wa(2, 2, 0), 32'h1234_5678, "R6");
        r0 = rd_count;
        cpu_op(1'b0, wa(2, 2, 0), 0, "R10 load of posted word");
        check(rd_count - r0 == 8, "R6 store miss not allocated", rd_count - r0, 8);

        // R7: write-back store miss allocates, fills and merges
        wb_mode = 1'b1;
        wr_a.delete(); wr_d.delete();
        r0 = rd_count;
        cpu_op(1'b1, wa(3, 2, 4), 32'h0BAD_F00D, "R7");
        check(rd_count - r0 == 8, "R7 store miss fills", rd_count - r0, 8);
        r0 = rd_count;
        cpu_op(1'b0, wa(3, 2, 4), 0, "R7 merged word");
        cpu_op(1'b0, wa(3, 2, 0), 0, "R7 filled word");
        check(rd_count - r0 == 0, "R7 line resident", rd_count - r0, 0);
        check(wr_a.size() == 0, "R7 no write", wr_a.size(), 0);

        // R3/R5/R8: 64 tags in set 3, round-robin eviction
        cpu_op(1'b1, wa(16, 3, 5), 32'hCAFE_0005, "R5");
        for (int t = 1; t < 64; t++) cpu_op(1'b0, wa(16 + t, 3, 0), 0, "R3 set fill load");
        r0 = rd_count;
        cpu_op(1'b0, wa(16 + 1, 3, 1), 0, "R3 resident");
        check(rd_count - r0 == 0, "R3 64 ways resident", rd_count - r0, 0);
        wr_a.delete(); wr_d.delete();
        cpu_op(1'b0, wa(80, 3, 0), 0, "R5 evicting load");
        check(wr_a.size() == 4, "R5 one dirty half written", wr_a.size(), 4);
        if (wr_a.size() == 4) begin
            for (int k = 0; k < 4; k++)
                check(wr_a[k] == wa(16, 3, 4 + k), "R5 burst address", 32'(wr_a[k]), 32'(wa(16, 3, 4 + k)));
            check(wr_d[1] == 32'hCAFE_0005, "R5 dirty word", wr_d[1], 32'hCAFE_0005);
        end
        wr_a.delete(); wr_d.delete();
        cpu_op(1'b0, wa(81, 3, 0), 0, "R5 clean evicting load");
        check(wr_a.size() == 0, "R5 clean victim no write", wr_a.size(), 0);
        r0 = rd_count;
        cpu_op(1'b0, wa(18, 3, 2), 0, "R8 way 2 data");
        check(rd_count - r0 == 0, "R8 way 2 kept", rd_count - r0, 0);
        r0 = rd_count;
        cpu_op(1'b0, wa(16, 3, 5), 0, "R8 reload evicted line");
        check(rd_count - r0 == 8, "R8 way 0 evicted", rd_count - r0, 8);

        // R9/R11: buffer capacity and FIFO order under a stalled memory
        wb_mode = 1'b0;
        wr_a.delete(); wr_d.delete();
        mem_hold = 1'b1;
        for (int k = 0; k < 4; k++) cpu_op(1'b1, wa(16 + k, 5, k), 32'hF000_0000 + k, "R9");
        r0 = ops_done;
        fork
            cpu_op(1'b1, wa(20, 5, 4), 32'hF000_0004, "R9");
            begin
                repeat (30) @(negedge clk);
                check(ops_done == r0, "R9 store stalls when full", ops_done, r0);
                check(mem_req && mem_addr == wa(16, 5, 0), "R11 request held", 32'(mem_addr), 32'(wa(16, 5, 0)));
                mem_hold = 1'b0;
            end
        join
        repeat (40) @(negedge clk);
        check(wr_a.size() == 5, "R9 all posted", wr_a.size(), 5);
        if (wr_a.size() == 5)
            for (int k = 0; k < 5; k++)
                check(wr_a[k] == wa(16 + k, 5, k) && wr_d[k] == 32'hF000_0000 + k, "R9 FIFO order", wr_d[k], 32'hF000_0000 + k);

        // R8: pseudo-random replacement keeps data correct
        wb_mode = 1'b1;
        rand_repl = 1'b1;
        for (int t = 0; t < 8; t++) cpu_op(1'b1, wa(16 + t, 6, t), 32'hA000_0000 + t, "R8");
        for (int t = 8; t < 72; t++) cpu_op(1'b0, wa(16 + t, 6, 0), 0, "R8 random fill");
        for (int t = 0; t < 8; t++) cpu_op(1'b0, wa(16 + t, 6, t), 0, "R8 random reload");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all loads answered", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule